// File: doc/BRIEF.md
# Completion Interrupt Moderation Timers

This block sits between the source of completion pulses for one transfer direction and the interrupt line a host handler sees. Reporting each completion on its own costs a handler invocation per completion. The block holds completions back and reports them as one DONE pulse. Two timers decide when that pulse goes out. The burst timer caps how long the oldest unreported completion may wait. The idle timer reports once the completion stream has gone quiet for a programmed gap. The pulse is sent by whichever timer expires first.

Software programs each timer through a small write port. Each timer has a control word with clear, enable and time-base bits, plus a threshold word. A timer counts either core clock cycles or the pulses on an external 1 µs strobe. When both timers are disabled, every completion is forwarded one cycle later. A separate buffer-nearly-full input is never delayed: it is forwarded as an overflow-risk interrupt one cycle later in every mode.

Top module: `imod_core`

## Requirements
- R1: After reset, done_o and ovf_risk_o are low and both timers are disabled, so moderation is off.
- R2: With both timers disabled, done_o is high in the cycle after each cycle in which done_raw_i is high.
- R3: The config port takes address 0 as the burst control word and address 1 as the burst threshold. Control bits are bit 0 clear, bit 1 enable and bit 2 time base. The burst timer starts at the first completion after a report, and later completions do not restart it. It fires on the step that brings its count to the threshold. In clock mode with threshold T ≥ 1, done_o rises T cycles after the first completion's edge.
- R4: Address 2 is the idle control word and address 3 is the idle threshold, with the same bit layout as the burst words. The idle timer restarts on every completion. It fires after threshold steps with no completion. done_o rises T cycles after the last completion's edge.
- R5: With both timers enabled, the first timer to expire produces exactly one done_o pulse, and then both timers return to zero.
- R6: With the time-base bit set, a timer advances only in cycles in which tick_us_i is high.
- R7: A control write with bit 0 set clears that timer and disables it, whatever bits 1 and 2 hold. The other timer is unaffected.
- R8: A threshold of 0 behaves like 1: the timer fires on the first step after a completion.
- R9: ovf_risk_o equals hi_thr_i delayed by one cycle, in every mode and regardless of pending completions.
- R10: If both timers become disabled while a completion is pending, done_o pulses once in the next cycle.
- R11: A completion in the same cycle as a firing is not absorbed. It stays pending and starts a new moderation round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 2 | Config word select |
| cfg_wdata_i | input | CNT_W | Config write data |
| done_raw_i | input | 1 | Raw completion pulse |
| tick_us_i | input | 1 | 1 µs strobe |
| hi_thr_i | input | 1 | Buffer high-threshold indication |
| done_o | output | 1 | Moderated completion interrupt |
| ovf_risk_o | output | 1 | Overflow-risk interrupt |

## Verification
A completion stream that never pauses lets the burst timer expire while the idle timer keeps restarting. This separates the burst timer from the idle timer, and it also lands a completion on the firing cycle. A pair of completions with a gap, under the idle timer alone, shows that each completion restarts the count; a burst timer would have fired earlier. A strobe that arrives only now and then separates tick counting from clock counting. A clear written in the middle of a round, and the disabling of the last enabled timer, show which timer owns the pulse and that the pending completion is flushed.

// File: rtl/imod_pkg.sv
package imod_pkg;
  localparam int NUM_TMR   = 2;
  localparam int TMR_BURST = 0;
  localparam int TMR_IDLE  = 1;
  localparam int CTL_CLR   = 0;
  localparam int CTL_EN    = 1;
  localparam int CTL_SEL   = 2;

  typedef struct packed {
    logic en;
    logic tick_sel;
  } tmr_ctl_t;
endpackage

// File: rtl/imod_regs.sv
module imod_regs
  import imod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output tmr_ctl_t         ctl_o    [NUM_TMR],
  output logic [CNT_W-1:0] thr_o    [NUM_TMR],
  output logic             clr_wr_o [NUM_TMR]
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam logic [1:0] CTL_ADDR = 2'(2 * g);
    localparam logic [1:0] THR_ADDR = 2'(2 * g + 1);
    logic ctl_wr, thr_wr;

    assign ctl_wr         = we_i && (addr_i == CTL_ADDR);
    assign thr_wr         = we_i && (addr_i == THR_ADDR);
    assign clr_wr_o[g]    = ctl_wr && wdata_i[CTL_CLR];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[g] <= '0;
        thr_o[g] <= '0;
      end else begin
        if (ctl_wr) begin
          if (wdata_i[CTL_CLR]) ctl_o[g] <= '0;
          else begin
            ctl_o[g].en       <= wdata_i[CTL_EN];
            ctl_o[g].tick_sel <= wdata_i[CTL_SEL];
          end
        end
        if (thr_wr) thr_o[g] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/imod_timer.sv
module imod_timer
  import imod_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter bit RESTART_ON_EVT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_ctl_t         ctl_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             tick_i,
  input  logic             pending_i,
  input  logic             event_i,
  input  logic             clr_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;
  logic             restart;
  logic [CNT_W:0]   cnt_inc;

  assign step    = ctl_i.tick_sel ? tick_i : 1'b1;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  // idle variant restarts on each completion; burst variant ignores them
  if (RESTART_ON_EVT) begin : g_idle
    assign restart = event_i;
  end else begin : g_burst
    assign restart = 1'b0;
  end

  assign fire_o = ctl_i.en && pending_i && step && !restart &&
                  (cnt_inc >= {1'b0, thr_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      cnt_q <= '0;
    else if (clr_i || !ctl_i.en || !pending_i || restart) cnt_q <= '0;
    else if (step && !(&cnt_q))                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/imod_core.sv
module imod_core
  import imod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  input  logic             done_raw_i,
  input  logic             tick_us_i,
  input  logic             hi_thr_i,
  output logic             done_o,
  output logic             ovf_risk_o
);
  tmr_ctl_t         ctl    [NUM_TMR];
  logic [CNT_W-1:0] thr    [NUM_TMR];
  logic             clr_wr [NUM_TMR];
  logic [NUM_TMR-1:0] fire_v;
  logic             fire, mod_off, pending_q;

  imod_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .ctl_o    (ctl),
    .thr_o    (thr),
    .clr_wr_o (clr_wr)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    imod_timer #(
      .CNT_W          (CNT_W),
      .RESTART_ON_EVT (g == TMR_IDLE)
    ) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_i     (ctl[g]),
      .thr_i     (thr[g]),
      .tick_i    (tick_us_i),
      .pending_i (pending_q),
      .event_i   (done_raw_i),
      .clr_i     (clr_wr[g] || fire),
      .fire_o    (fire_v[g])
    );
  end

  assign fire    = |fire_v;
  assign mod_off = !ctl[TMR_BURST].en && !ctl[TMR_IDLE].en;

  // R1: all outputs and pending state low out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q  <= 1'b0;
      done_o     <= 1'b0;
      ovf_risk_o <= 1'b0;
    end else begin
      ovf_risk_o <= hi_thr_i;
      if (mod_off) begin
        done_o    <= done_raw_i || pending_q;  // pass-through and flush
        pending_q <= 1'b0;
      end else begin
        done_o    <= fire;
        pending_q <= fire ? done_raw_i : (pending_q || done_raw_i);
      end
    end
  end
endmodule

// File: rtl/imod_core_chk.sv
module imod_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [1:0] cfg_addr_i,
  input logic       cfg_clr_bit,
  input logic       done_raw_i,
  input logic       hi_thr_i,
  input logic       done_o,
  input logic       ovf_risk_o,
  input logic       mod_off,
  input logic       fire,
  input logic       pending_q,
  input logic       burst_en
);
  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_thr_i |=> ovf_risk_o);
  p_ovf_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_thr_i |=> !ovf_risk_o);
  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_off && done_raw_i) |=> done_o);
  p_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_off && !fire) |=> !done_o);
  p_fire_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> (pending_q && !mod_off));
  p_coincide_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_off && fire) |=> (pending_q == $past(done_raw_i)));
  p_clr_dis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 2'd0 && cfg_clr_bit) |=> !burst_en);
  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_off && pending_q) |=> (done_o && !pending_q));
endmodule

bind imod_core imod_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_clr_bit (cfg_wdata_i[0]),
  .done_raw_i  (done_raw_i),
  .hi_thr_i    (hi_thr_i),
  .done_o      (done_o),
  .ovf_risk_o  (ovf_risk_o),
  .mod_off     (mod_off),
  .fire        (fire),
  .pending_q   (pending_q),
  .burst_en    (ctl[0].en)
);

// File: tb/imod_core_bench.sv
module imod_core_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        done_raw_i = 1'b0;
  logic        tick_us_i = 1'b0;
  logic        hi_thr_i = 1'b0;
  logic        done_o, ovf_risk_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #5 clk_i = ~clk_i;

  imod_core #(.CNT_W(16)) u_imod_core (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .done_raw_i, .tick_us_i, .hi_thr_i, .done_o, .ovf_risk_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    cyc();
    cfg_we_i = 1'b0;
  endtask

  task automatic comp();
    done_raw_i = 1'b1;
    cyc();
    done_raw_i = 1'b0;
  endtask

  task automatic quiesce();
    cfg(2'd0, 16'h1); cfg(2'd2, 16'h1);
    cfg(2'd1, 16'h0); cfg(2'd3, 16'h0);
    repeat (3) cyc();
  endtask

  task automatic t_reset();
    chk("R1 done", done_o, 0);
    chk("R1 ovf", ovf_risk_o, 0);
    comp();
    chk("R1 moderation off", done_o, 1);
    cyc();
  endtask

  task automatic t_pass();
    quiesce();
    comp();
    chk("R2 single", done_o, 1);
    cyc();
    chk("R2 single end", done_o, 0);
    done_raw_i = 1'b1;
    cyc(); chk("R2 run a", done_o, 1);
    cyc(); chk("R2 run b", done_o, 1);
    done_raw_i = 1'b0;
    cyc(); chk("R2 run end", done_o, 0);
  endtask

  task automatic t_burst();
    int cnt = 0;
    quiesce();
    cfg(2'd1, 16'd4); cfg(2'd0, 16'h2);
    comp(); comp(); comp();
    cyc(); chk("R3 early", done_o, 0);
    cyc(); chk("R3 fire", done_o, 1);
    for (int i = 0; i < 8; i++) begin cyc(); cnt += done_o; end
    chk("R3 single pulse", cnt, 0);
  endtask

  task automatic t_idle();
    quiesce();
    cfg(2'd3, 16'd3); cfg(2'd2, 16'h2);
    comp(); cyc(); comp();
    cyc(); chk("R4 restart a", done_o, 0);
    cyc(); chk("R4 restart b", done_o, 0);
    cyc(); chk("R4 fire", done_o, 1);
  endtask

  task automatic t_both();
    int cnt = 0;
    quiesce();
    cfg(2'd1, 16'd5); cfg(2'd3, 16'd2);
    cfg(2'd0, 16'h2); cfg(2'd2, 16'h2);
    for (int i = 0; i < 16; i++) begin
      done_raw_i = (i < 8);
      cyc();
      cnt += done_o;
      if (i == 5) chk("R5 burst first, R11 coincident", done_o, 1);
      if (i == 9) chk("R5 idle after stream R11", done_o, 1);
    end
    done_raw_i = 1'b0;
    chk("R5 pulse count", cnt, 2);
  endtask

  task automatic t_tick();
    quiesce();
    cfg(2'd1, 16'd2); cfg(2'd0, 16'h6);
    comp();
    repeat (6) cyc();
    chk("R6 no tick", done_o, 0);
    tick_us_i = 1'b1; cyc(); tick_us_i = 1'b0;
    chk("R6 one tick", done_o, 0);
    repeat (3) cyc();
    chk("R6 held", done_o, 0);
    tick_us_i = 1'b1; cyc(); tick_us_i = 1'b0;
    chk("R6 two ticks", done_o, 1);
  endtask

  task automatic t_zero();
    quiesce();
    cfg(2'd0, 16'h2);
    comp();
    chk("R8 not yet", done_o, 0);
    cyc();
    chk("R8 first step", done_o, 1);
  endtask

  task automatic t_clr();
    int cnt = 0;
    quiesce();
    cfg(2'd1, 16'd3); cfg(2'd3, 16'd20);
    cfg(2'd0, 16'h2); cfg(2'd2, 16'h2);
    comp();
    cfg(2'd0, 16'h7);
    for (int i = 0; i < 18; i++) begin cyc(); cnt += done_o; end
    chk("R7 burst cleared", cnt, 0);
    cyc();
    chk("R7 idle still runs", done_o, 1);
  endtask

  task automatic t_flush();
    quiesce();
    cfg(2'd3, 16'd20); cfg(2'd2, 16'h2);
    comp();
    cfg(2'd2, 16'h1);
    chk("R10 before", done_o, 0);
    cyc(); chk("R10 flush", done_o, 1);
    cyc(); chk("R10 once", done_o, 0);
  endtask

  task automatic t_ovf();
    quiesce();
    cfg(2'd1, 16'd50); cfg(2'd0, 16'h2);
    comp();
    hi_thr_i = 1'b1; cyc(); hi_thr_i = 1'b0;
    chk("R9 ovf passes", ovf_risk_o, 1);
    chk("R9 done held", done_o, 0);
    cyc();
    chk("R9 ovf drops", ovf_risk_o, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_pass();
    t_burst();
    t_idle();
    t_both();
    t_tick();
    t_zero();
    t_clr();
    t_flush();
    t_ovf();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule